// File: doc/BRIEF.md
# Zero-Turnaround Late-Write Synchronous SRAM

A synthesizable behavioural model of a single-port synchronous SRAM whose data bus never needs an idle cycle. Reads and writes may follow one another in any order on consecutive clocks. A write command is taken on one rising edge, and its data follows one or two edges later. This removes the bus turnaround a conventional SRAM needs when it switches from read to write.

A static mode input selects between a registered-output (pipelined) mode and an unregistered-output (flow-through) mode. Each mode has its own read latency and write-data lag. The block also provides:
- internally generated 4-beat bursts in linear or interleaved order;
- per-lane write enables over 9-bit byte lanes;
- three chip selects with mixed polarity;
- an asynchronous output enable and a sleep input.

The bidirectional data bus is split into `d_i`, `q_o` and `q_oe_o`.

Top module: `nbt_sram`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it rises, `q_oe_o` is 0. Reset discards commands in flight and any write data they still expect; the array keeps its contents.
- R2: A new access starts on an edge where `adv_i`=0, `sel_a_ni`=0, `sel_b_i`=1, `sel_c_ni`=0 and `sleep_i`=0. It is a write when `we_ni`=0 and a read when `we_ni`=1. Any other select combination without `adv_i` is a deselect: the array is unchanged and the output is off at that command's output stage.
- R3: With `flow_mode_i`=0, read data for a command taken at edge N is driven from edge N+1 to edge N+2. Write data for a command taken at edge N is sampled on `d_i` at edge N+2.
- R4: With `flow_mode_i`=1, read data for a command taken at edge N is driven from edge N to edge N+1. Write data for a command taken at edge N is sampled on `d_i` at edge N+1.
- R5: Any sequence of reads, writes and deselects runs back to back with no idle cycle. A read always returns the latest data written to that address, including write data that arrives on the same edge on which the read's output is captured.
- R6: Data lane k is bits [9k+8:9k]. It is written only when `bw_ni[k]`=0 on the command edge; the other lanes keep their contents.
- R7: An edge with `adv_i`=1 during an active burst repeats the burst's read or write type and ignores the selects, `we_ni` and `addr_i`. The beat counter k steps 1,2,3,0 and so on. The low two address bits are (base+k) mod 4 when `burst_ilv_i`=0 and base XOR k when it is 1; the upper address bits stay those of the base.
- R8: An edge with `adv_i`=1 while no burst is active (after reset, a deselect or a sleep edge) is a deselect.
- R9: `oe_ni`=1 forces `q_oe_o` to 0 immediately and does not disturb the read pipeline.
- R10: While `sleep_i`=1, `q_oe_o` is 0 and each edge is a deselect that also ends the burst. Writes issued earlier still take their data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flow_mode_i | input | 1 | 1 = flow-through, 0 = pipelined (static) |
| burst_ilv_i | input | 1 | 1 = interleaved burst order, 0 = linear (static) |
| sleep_i | input | 1 | Power-down: blocks accesses, outputs off |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| sel_a_ni | input | 1 | Chip select, active low |
| sel_b_i | input | 1 | Chip select, active high |
| sel_c_ni | input | 1 | Chip select, active low |
| adv_i | input | 1 | Continue current burst |
| we_ni | input | 1 | 0 = write, 1 = read |
| addr_i | input | ADDR_W | Word address |
| bw_ni | input | NBYTES | Byte lane write enables, active low |
| d_i | input | NBYTES*BYTE_W | Write data, late |
| q_o | output | NBYTES*BYTE_W | Read data, 0 when not driven |
| q_oe_o | output | 1 | Data bus drive enable |

## Verification
The bench aims at a read issued the cycle after a write to the same address in pipelined mode. Without forwarding, that read would return the old word, because the write data arrives on the same edge the output register captures. Burst wrap in both orders is exercised, along with advance edges that carry random selects and addresses. A design that took the address from the pins, or miscounted the beat, would read the wrong word. Random sleep, output-enable and deselect patterns with partial writes show whether the output stage is gated at the wrong pipeline stage, or whether a masked lane is overwritten.

// File: rtl/nbt_sram_pkg.sv
package nbt_sram_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  function automatic logic [1:0] beat_lo(input logic [1:0] base, input logic [1:0] idx,
                                         input logic ilv);
    return ilv ? (base ^ idx) : (base + idx);
  endfunction
endpackage

// File: rtl/nbt_sram_ctrl.sv
module nbt_sram_ctrl
  import nbt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_i,
  input  logic              burst_ilv_i,
  input  logic              sel_a_ni,
  input  logic              sel_b_i,
  input  logic              sel_c_ni,
  input  logic              we_ni,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NBYTES-1:0] bw_ni,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [NBYTES-1:0] be_o
);
  logic              act_q, wr_q, start;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        beat_q, beat_d;

  always_comb begin
    start  = ~sleep_i & ~adv_i & ~sel_a_ni & sel_b_i & ~sel_c_ni;
    beat_d = beat_q + 2'd1;
    op_o   = OP_NONE;
    addr_o = addr_i;
    be_o   = ~bw_ni;
    if (start) begin
      op_o = we_ni ? OP_RD : OP_WR;
    end else if (~sleep_i & adv_i & act_q) begin
      op_o   = wr_q ? OP_WR : OP_RD;
      addr_o = {base_q[ADDR_W-1:2], beat_lo(base_q[1:0], beat_d, burst_ilv_i)};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
    end else begin
      act_q <= (op_o != OP_NONE);
      if (start) begin
        base_q <= addr_i;
        wr_q   <= ~we_ni;
        beat_q <= '0;
      end else if (op_o != OP_NONE) begin
        beat_q <= beat_d;
      end
    end
  end
endmodule

// File: rtl/nbt_sram_wpipe.sv
module nbt_sram_wpipe
  import nbt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flow_mode_i,
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NBYTES-1:0] be_i,
  output logic              rd_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_go_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [NBYTES-1:0] wr_be_o,
  output logic              fwd_hit_o
);
  typedef struct packed {
    op_e               op;
    logic [ADDR_W-1:0] addr;
    logic [NBYTES-1:0] be;
  } stage_t;

  stage_t s1_q, s2_q, commit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= '{op: op_i, addr: addr_i, be: be_i};
      s2_q <= s1_q;
    end
  end

  // single late write commits stage 1, double late write commits stage 2
  assign commit    = flow_mode_i ? s1_q : s2_q;
  assign wr_go_o   = (commit.op == OP_WR);
  assign wr_addr_o = commit.addr;
  assign wr_be_o   = commit.be;
  assign rd_o      = (s1_q.op == OP_RD);
  assign rd_addr_o = s1_q.addr;
  assign fwd_hit_o = ~flow_mode_i & (s2_q.op == OP_WR) & (s1_q.op == OP_RD)
                   & (s2_q.addr == s1_q.addr);
endmodule

// File: rtl/nbt_sram_array.sv
module nbt_sram_array #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 9
) (
  input  logic                     clk_i,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        waddr_i,
  input  logic [NBYTES-1:0]        wbe_i,
  input  logic [NBYTES*BYTE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]        raddr_i,
  output logic [NBYTES*BYTE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] mem_q [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && wbe_i[b]) mem_q[waddr_i] <= wdata_i[b*BYTE_W +: BYTE_W];
    end
    assign rdata_o[b*BYTE_W +: BYTE_W] = mem_q[raddr_i];
  end
endmodule

// File: rtl/nbt_sram.sv
module nbt_sram
  import nbt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 9
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     flow_mode_i,
  input  logic                     burst_ilv_i,
  input  logic                     sleep_i,
  input  logic                     oe_ni,
  input  logic                     sel_a_ni,
  input  logic                     sel_b_i,
  input  logic                     sel_c_ni,
  input  logic                     adv_i,
  input  logic                     we_ni,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [NBYTES-1:0]        bw_ni,
  input  logic [NBYTES*BYTE_W-1:0] d_i,
  output logic [NBYTES*BYTE_W-1:0] q_o,
  output logic                     q_oe_o
);
  localparam int DATA_W = NBYTES * BYTE_W;

  op_e               cmd_op;
  logic [ADDR_W-1:0] cmd_addr, rd_addr, wr_addr;
  logic [NBYTES-1:0] cmd_be, wr_be;
  logic              rd1, wr_go, fwd_hit, q_vld_q, drv_vld;
  logic [DATA_W-1:0] rd_data, cap_data, q_q, drv_data;

  nbt_sram_ctrl #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_ctrl (
    .clk_i, .rst_ni, .sleep_i, .burst_ilv_i, .sel_a_ni, .sel_b_i, .sel_c_ni,
    .we_ni, .adv_i, .addr_i, .bw_ni,
    .op_o(cmd_op), .addr_o(cmd_addr), .be_o(cmd_be)
  );

  nbt_sram_wpipe #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_wpipe (
    .clk_i, .rst_ni, .flow_mode_i,
    .op_i(cmd_op), .addr_i(cmd_addr), .be_i(cmd_be),
    .rd_o(rd1), .rd_addr_o(rd_addr),
    .wr_go_o(wr_go), .wr_addr_o(wr_addr), .wr_be_o(wr_be), .fwd_hit_o(fwd_hit)
  );

  nbt_sram_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_array (
    .clk_i, .we_i(wr_go), .waddr_i(wr_addr), .wbe_i(wr_be), .wdata_i(d_i),
    .raddr_i(rd_addr), .rdata_o(rd_data)
  );

  // same-edge forwarding of late write data into the output register
  for (genvar b = 0; b < NBYTES; b++) begin : g_fwd
    assign cap_data[b*BYTE_W +: BYTE_W] = (fwd_hit && wr_be[b]) ? d_i[b*BYTE_W +: BYTE_W]
                                                                : rd_data[b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_vld_q <= 1'b0;
      q_q     <= '0;
    end else begin
      q_vld_q <= ~flow_mode_i & rd1;
      if (rd1) q_q <= cap_data;
    end
  end

  assign drv_vld  = flow_mode_i ? rd1 : q_vld_q;
  assign drv_data = flow_mode_i ? rd_data : q_q;
  assign q_oe_o   = drv_vld & ~oe_ni & ~sleep_i;
  assign q_o      = q_oe_o ? drv_data : '0;
endmodule

// File: rtl/nbt_sram_chk.sv
module nbt_sram_chk #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 9
) (
  input logic clk_i,
  input logic rst_ni,
  input logic flow_mode_i,
  input logic sleep_i,
  input logic oe_ni,
  input logic sel_a_ni,
  input logic sel_b_i,
  input logic sel_c_ni,
  input logic adv_i,
  input logic we_ni,
  input logic q_oe_o
);
  logic sel, idle, rd_new;
  assign sel    = ~sel_a_ni & sel_b_i & ~sel_c_ni;
  assign idle   = sleep_i | (~adv_i & ~sel);
  assign rd_new = ~sleep_i & ~adv_i & sel & we_ni;

  a_r1_off_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rst_ni) |-> !q_oe_o);
  a_r9_oe_forces_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !q_oe_o);
  a_r10_sleep_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !q_oe_o);
  a_r2_flow_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flow_mode_i && idle) |=> !q_oe_o);
  a_r2_pipe_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flow_mode_i && idle) |=> ##1 !q_oe_o);
  a_r4_flow_read_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flow_mode_i && rd_new) |=> (q_oe_o || oe_ni || sleep_i));
  a_r3_pipe_read_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flow_mode_i && rd_new) |=> ##1 (q_oe_o || oe_ni || sleep_i));
endmodule

bind nbt_sram nbt_sram_chk #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .flow_mode_i(flow_mode_i), .sleep_i(sleep_i),
  .oe_ni(oe_ni), .sel_a_ni(sel_a_ni), .sel_b_i(sel_b_i), .sel_c_ni(sel_c_ni),
  .adv_i(adv_i), .we_ni(we_ni), .q_oe_o(q_oe_o)
);

// File: tb/nbt_sram_tb_top.sv
module nbt_sram_tb_top;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int BW = 9;
  localparam int DW = NB * BW;
  localparam int K_IDLE = 0, K_RD = 1, K_WR = 2, K_ADV = 3, K_PART = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0, flow_mode_i = 1'b1, burst_ilv_i = 1'b0, sleep_i = 1'b0, oe_ni = 1'b0;
  logic sel_a_ni = 1'b1, sel_b_i = 1'b0, sel_c_ni = 1'b1, adv_i = 1'b0, we_ni = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [NB-1:0] bw_ni = '1;
  logic [DW-1:0] d_i = '0, q_o;
  logic          q_oe_o;

  always #5 clk = ~clk;

  nbt_sram #(.ADDR_W(AW), .NBYTES(NB), .BYTE_W(BW)) dut_i (
    .clk_i(clk), .rst_ni, .flow_mode_i, .burst_ilv_i, .sleep_i, .oe_ni,
    .sel_a_ni, .sel_b_i, .sel_c_ni, .adv_i, .we_ni, .addr_i, .bw_ni, .d_i, .q_o, .q_oe_o
  );

  int    nchk = 0, nfail = 0, ecnt = 0;
  string tag = "R1";
  bit    done = 1'b0;

  // reference model state
  typedef struct {int due; int addr; logic [NB-1:0] be;} pw_t;
  pw_t           pq[$];
  logic [DW-1:0] mm [1<<AW];
  bit            raw = 0, prd = 0, m_act = 0, m_wr = 0;
  int            pra = 0, m_base = 0, m_beat = 0;
  logic [DW-1:0] qx = '0;
  logic [DW-1:0] dsched [int];

  function automatic logic [DW-1:0] rnd();
    logic [63:0] t = {$urandom, $urandom};
    return t[DW-1:0];
  endfunction

  always @(posedge clk) begin
    int op, a, lo;
    bit fl;
    ecnt++;
    if (!rst_ni) begin
      pq.delete();
      m_act = 0; raw = 0; prd = 0;
    end else begin
      for (int i = pq.size() - 1; i >= 0; i--) begin
        if (pq[i].due == ecnt) begin
          for (int b = 0; b < NB; b++)
            if (pq[i].be[b]) mm[pq[i].addr][b*BW +: BW] = d_i[b*BW +: BW];
          pq.delete(i);
        end
      end
      fl = flow_mode_i;
      if (!fl) begin
        raw = prd;
        if (prd) qx = mm[pra];
      end
      op = 0;
      a  = int'(addr_i);
      if (!sleep_i && !adv_i && !sel_a_ni && sel_b_i && !sel_c_ni) begin
        op = we_ni ? 1 : 2;
        m_act = 1; m_wr = !we_ni; m_base = a; m_beat = 0;
      end else if (!sleep_i && adv_i && m_act) begin
        m_beat = (m_beat + 1) % 4;
        lo = burst_ilv_i ? ((m_base % 4) ^ m_beat) : ((m_base + m_beat) % 4);
        a  = (m_base / 4) * 4 + lo;
        op = m_wr ? 2 : 1;
      end else begin
        m_act = 0;
      end
      if (op == 2) pq.push_back('{ecnt + (fl ? 1 : 2), a, ~bw_ni});
      if (fl) begin
        raw = (op == 1);
        if (op == 1) qx = mm[a];
      end else begin
        prd = (op == 1);
        pra = a;
      end
    end
  end

  always @(negedge clk) begin
    bit eo;
    if (rst_ni && !done) begin
      eo = raw && !oe_ni && !sleep_i;
      nchk++;
      if (q_oe_o !== eo || (eo && q_o !== qx)) begin
        nfail++;
        $display("FAIL %s edge %0d: q_oe_o=%0b q_o=%h expected oe=%0b q=%h",
                 tag, ecnt, q_oe_o, q_o, eo, eo ? qx : '0);
      end
    end
  end

  task automatic step(input int kind, input int addr, input logic [NB-1:0] bwn);
    @(posedge clk);
    #1;
    d_i = dsched.exists(ecnt + 1) ? dsched[ecnt + 1] : rnd();
    dsched[ecnt + 1 + (flow_mode_i ? 1 : 2)] = rnd();
    sel_a_ni = 1'b0; sel_b_i = 1'b1; sel_c_ni = 1'b0;
    adv_i = 1'b0; we_ni = 1'b1;
    addr_i = AW'(addr); bw_ni = bwn;
    case (kind)
      K_IDLE: sel_b_i = 1'b0;
      K_WR:   we_ni = 1'b0;
      K_ADV: begin
        adv_i = 1'b1;
        sel_a_ni = 1'($urandom); sel_b_i = 1'($urandom); sel_c_ni = 1'($urandom);
        we_ni = 1'($urandom);
      end
      K_PART: begin
        we_ni = 1'b0;
        case (addr % 3)
          0: sel_a_ni = 1'b1;
          1: sel_b_i = 1'b0;
          default: sel_c_ni = 1'b1;
        endcase
      end
      default: ;
    endcase
  endtask

  task automatic do_reset(input bit fl, input bit ilv);
    @(posedge clk);
    #1;
    rst_ni = 1'b0; flow_mode_i = fl; burst_ilv_i = ilv; oe_ni = 1'b0; sleep_i = 1'b0;
    sel_b_i = 1'b0; adv_i = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
  endtask

  task automatic stress(input int n, input int amax);
    for (int i = 0; i < n; i++) begin
      int r = $urandom_range(0, 9);
      int k = (r < 3) ? K_RD : (r < 6) ? K_WR : (r < 8) ? K_ADV : (r == 8) ? K_IDLE : K_PART;
      oe_ni   = ($urandom_range(0, 7) == 0);
      sleep_i = ($urandom_range(0, 11) == 0);
      step(k, $urandom_range(0, amax), NB'($urandom_range(0, 15)));
    end
    oe_ni = 1'b0; sleep_i = 1'b0;
  endtask

  task automatic burst_set(input int a0);
    step(K_RD, a0, '1);
    for (int i = 0; i < 5; i++) step(K_ADV, $urandom_range(0, 63), '1);
    step(K_WR, a0 + 5, '0);
    for (int i = 0; i < 4; i++) step(K_ADV, $urandom_range(0, 63), NB'(i));
    step(K_RD, a0 + 5, '1);
    for (int i = 0; i < 4; i++) step(K_ADV, 0, '1);
  endtask

  task automatic async_set();
    tag = "R9";
    step(K_RD, 3, '1); oe_ni = 1'b1; step(K_RD, 4, '1); step(K_IDLE, 0, '1);
    oe_ni = 1'b0; step(K_RD, 5, '1); step(K_IDLE, 0, '1); step(K_IDLE, 0, '1);
    tag = "R10";
    sleep_i = 1'b1; step(K_WR, 30, '0); step(K_RD, 30, '1);
    sleep_i = 1'b0; step(K_RD, 30, '1); step(K_WR, 31, '0);
    sleep_i = 1'b1; step(K_IDLE, 0, '1); sleep_i = 1'b0;
    step(K_RD, 31, '1); step(K_RD, 6, '1);
    sleep_i = 1'b1; step(K_ADV, 0, '1); sleep_i = 1'b0;
    step(K_ADV, 0, '1); step(K_IDLE, 0, '1); step(K_IDLE, 0, '1);
  endtask

  task automatic lane_set(input int a);
    tag = "R6";
    for (int i = 0; i < 16; i++) begin
      step(K_WR, a, NB'(i));
      step(K_RD, a, '1);
    end
  endtask

  initial begin
    do_reset(1'b1, 1'b0);
    tag = "R1";
    repeat (3) step(K_IDLE, 0, '1);
    tag = "R4";
    for (int a = 0; a < (1 << AW); a++) step(K_WR, a, '0);
    for (int a = 0; a < (1 << AW); a++) step(K_RD, a, '1);
    tag = "R5";
    for (int i = 0; i < 16; i++) begin
      step(K_WR, i % 4, '0); step(K_RD, i % 4, '1); step(K_RD, (i + 1) % 4, '1);
    end
    lane_set(20);
    tag = "R7";
    burst_set(6);
    tag = "R8";
    step(K_IDLE, 0, '1); step(K_ADV, 0, '1); step(K_ADV, 0, '1);
    step(K_PART, 9, '1); step(K_ADV, 0, '1); step(K_RD, 9, '1);
    async_set();
    tag = "R2";
    for (int i = 0; i < 6; i++) step(K_PART, 40 + i, '0);
    for (int i = 0; i < 6; i++) step(K_RD, 40 + i, '1);
    tag = "R5";
    stress(400, 7);

    do_reset(1'b1, 1'b1);
    tag = "R7";
    burst_set(17);

    do_reset(1'b0, 1'b1);
    tag = "R1";
    repeat (3) step(K_IDLE, 0, '1);
    tag = "R3";
    for (int a = 0; a < 16; a++) step(K_RD, a, '1);
    for (int i = 0; i < 12; i++) begin
      step(K_WR, i % 3, '0); step(K_RD, i % 3, '1); step(K_IDLE, 0, '1);
    end
    tag = "R5";
    for (int i = 0; i < 16; i++) begin
      step(K_WR, i % 4, NB'(i)); step(K_RD, i % 4, '1); step(K_RD, (i + 3) % 4, '1);
    end
    lane_set(21);
    tag = "R7";
    burst_set(34);
    async_set();
    tag = "R5";
    stress(400, 7);

    do_reset(1'b0, 1'b0);
    tag = "R7";
    burst_set(50);
    tag = "R5";
    stress(200, 15);
    repeat (3) step(K_IDLE, 0, '1);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    #(100000 * 10);
    if (!done) begin
      done = 1'b1;
      nfail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule